// File: doc/BRIEF.md
# Frame-Synchronised Converter Serial Port

This block is the device-side digital port of a four-channel 14-bit sampling converter, as seen by a signal processor acting as serial master. The master owns the serial clock and a frame-sync line. Once the port has been enabled through its chip select, each frame-sync pulse opens one transaction. The master shifts in an eight-bit command, the port tells the analog front end which channel to acquire and when to sample, raises its own frame-sync output, and then returns the conversion result MSB first.

The port works on a fast system clock and treats the serial clock, chip select and frame-sync inputs as synchronous levels. It finds their edges by comparing each input with its value one system cycle earlier. Serial cycle k is the rising edge that follows the (k-1)th falling edge since the frame start, together with the kth falling edge. A transfer-width input picks a short frame of 24 serial cycles or a long frame of 32. The analog converter is not part of the block: its result arrives on a parallel input.

Top module: `dsp_fs_adc_if`

## Requirements
- R1: During and after reset, with no other stimulus, `shutdown` is 1, `dout`, `fs_out`, `sample_stb` and `acq_start` are 0, and `chan_sel` and `cmd_q` are 0.
- R2: A falling edge of `cs_n` while `fs_in` is low enables transactions. A falling edge of `cs_n` while `fs_in` is high leaves them disabled, and later frame-sync pulses produce no `sample_stb` and no `fs_out`.
- R3: The command is shifted in from `din` on the falling edges of cycles 1 to 8, first bit at `cmd_q[7]`. `chan_sel` takes the first two command bits, the first bit as `chan_sel[1]`.
- R4: `acq_start` pulses for one system cycle at the falling edge of cycle 3, and `chan_sel` updates on that same edge.
- R5: `sample_stb` pulses once per frame, for one system cycle, at the rising edge of cycle 7 when `wide_sel` is 0 and of cycle 15 when `wide_sel` is 1.
- R6: `fs_out` pulses once per frame, for one system cycle, at the rising edge of cycle 8 (narrow) or cycle 16 (wide). `result_in` is captured on that edge.
- R7: On the 16 rising edges after the `fs_out` edge, `dout` carries the captured 14-bit result MSB first and then two 0 bits. Before those edges `dout` is 0.
- R8: Any further serial-clock rising edges before the next frame sync drive `dout` to 0.
- R9: A falling edge of `fs_in` in the middle of a frame abandons that frame and restarts cycle counting and command capture. The new frame's strobes fall on its own cycle numbers and it returns its own result.
- R10: A rising edge of `cs_n` sets `shutdown`, forces `dout` to 0 and stops all pulses, even when further frame syncs or serial-clock edges follow. A falling edge of `cs_n` clears `shutdown`.
- R11: `wide_sel` is sampled on the frame-sync falling edge, and a change to it during the frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than `sclk` |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the master, idles low |
| fs_in | input | 1 | Frame sync from the master; its falling edge starts a frame |
| din | input | 1 | Serial command data |
| wide_sel | input | 1 | 0 selects the 24-cycle frame, 1 the 32-cycle frame |
| result_in | input | 14 | Parallel conversion result from the converter |
| dout | output | 1 | Serial result data |
| fs_out | output | 1 | Frame sync to the master, marks the start of the result |
| acq_start | output | 1 | Acquisition start pulse for the analog front end |
| sample_stb | output | 1 | Sample strobe for the analog front end |
| chan_sel | output | 2 | Channel selected by the current command |
| cmd_q | output | 8 | Command register |
| shutdown | output | 1 | 1 while the port is shut down |

## Verification
The assertions assume that `sclk` stays high and stays low for at least two system cycles. They also assume that no serial-clock edge lands in the same system cycle as a frame-sync or chip-select edge, so each strobe is one system cycle wide and is followed by a quiet cycle. The bench changes each master line on a falling system-clock edge and holds every serial-clock phase for three system cycles. It separates frame-sync pulses and chip-select changes from serial edges by idle system cycles, so every stimulus stays inside those assumptions.

// File: rtl/adc_dsp_pkg.sv
// Shared constants and types for the frame-synchronised converter port.
// Assumes nothing beyond being compiled ahead of the modules that import it.
package adc_dsp_pkg;
    localparam int CMD_BITS   = 8;   // command word length
    localparam int RES_BITS   = 14;  // converter result width
    localparam int SLOT_BITS  = 16;  // output slot width
    localparam int CHAN_BITS  = 2;   // channel field width
    localparam int CNT_BITS   = 6;   // serial cycle counter width
    localparam int ACQ_EDGE   = 3;   // falling edge that starts acquisition
    localparam int SMP_EDGE   = 7;   // rising edge that samples, narrow frame
    localparam int WIDE_EXTRA = 8;   // extra acquisition cycles, wide frame

    // Edge events of one synchronous input
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;
endpackage

// File: rtl/dsp_edge_det.sv
// Edge detector for a group of synchronous level inputs.
// Assumes the inputs are already synchronous to clk; each bit has its own
// reset value so that no edge is reported when reset releases.
module dsp_edge_det #(
    parameter int           N       = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic q;
        // Hold the previous level of this input
        always_ff @(posedge clk) begin
            if (!rst_n) q <= RST_VAL[i];
            else        q <= sig[i];
        end
        assign rise[i] = sig[i] & ~q;
        assign fall[i] = ~sig[i] & q;
    end
endmodule

// File: rtl/dsp_cmd_shift.sv
// Command capture: shifts din in on the first CMD_W falling edges of a frame
// and issues the acquisition start with the channel field.
// Assumes fall_evt is a single-cycle event and cnt counts falls before it.
module dsp_cmd_shift #(
    parameter int CMD_W  = 8,
    parameter int CHAN_W = 2,
    parameter int CNT_W  = 6,
    parameter int ACQ_N  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              fall_evt,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              din,
    output logic [CMD_W-1:0]  cmd_q,
    output logic [CHAN_W-1:0] chan_sel,
    output logic              acq_start
);
    localparam int              LEAD_HI = ACQ_N - 2;
    localparam logic [CNT_W-1:0] CAP_END = CNT_W'(CMD_W);
    localparam logic [CNT_W-1:0] ACQ_CNT = CNT_W'(ACQ_N - 1);

    // Shift command bits in, first bit ends at the MSB
    always_ff @(posedge clk) begin
        if (!rst_n || clear)                 cmd_q <= '0;
        else if (fall_evt && cnt < CAP_END)  cmd_q <= {cmd_q[CMD_W-2:0], din};
    end

    // Latch the channel and pulse acquisition start on the chosen falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_sel  <= '0;
            acq_start <= 1'b0;
        end else begin
            acq_start <= fall_evt && (cnt == ACQ_CNT);
            if (fall_evt && (cnt == ACQ_CNT))
                chan_sel <= cmd_q[LEAD_HI -: CHAN_W];
        end
    end
endmodule

// File: rtl/dsp_tx_shift.sv
// Result serializer: loads the result left-aligned into the output slot and
// shifts it out MSB first; the slot fills with zeros as it empties.
// Assumes load and shift are never requested in the same cycle.
module dsp_tx_shift #(
    parameter int RES_W  = 14,
    parameter int SLOT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic             shift,
    input  logic [RES_W-1:0] result_in,
    output logic             dout
);
    localparam int PAD_W = SLOT_W - RES_W;

    logic [SLOT_W-1:0] slot_q;

    // Hold, load or shift the output slot and drive the serial line
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            slot_q <= '0;
            dout   <= 1'b0;
        end else if (load) begin
            slot_q <= {result_in, {PAD_W{1'b0}}};
            dout   <= 1'b0;
        end else if (shift) begin
            dout   <= slot_q[SLOT_W-1];
            slot_q <= {slot_q[SLOT_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/dsp_fs_adc_if.sv
// Top of the frame-synchronised converter port. Counts serial cycles from the
// frame-sync falling edge, places the sample and frame-sync-out strobes on
// their cycle numbers, and handles abort by retrigger and by chip select.
// Assumes cs_n, sclk, fs_in and din are synchronous to clk and that sclk
// phases last at least two clk cycles.
module dsp_fs_adc_if
    import adc_dsp_pkg::*;
#(
    parameter int RES_W   = RES_BITS,
    parameter int SLOT_W  = SLOT_BITS,
    parameter int CMD_W   = CMD_BITS,
    parameter int CHAN_W  = CHAN_BITS,
    parameter int CNT_W   = CNT_BITS,
    parameter int ACQ_N   = ACQ_EDGE,
    parameter int SMP_N   = SMP_EDGE,
    parameter int EXTRA_N = WIDE_EXTRA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              fs_in,
    input  logic              din,
    input  logic              wide_sel,
    input  logic [RES_W-1:0]  result_in,
    output logic              dout,
    output logic              fs_out,
    output logic              acq_start,
    output logic              sample_stb,
    output logic [CHAN_W-1:0] chan_sel,
    output logic [CMD_W-1:0]  cmd_q,
    output logic              shutdown
);
    localparam int              RN_W       = CNT_W + 1;
    localparam logic [RN_W-1:0] SMP_NARROW = RN_W'(SMP_N);
    localparam logic [RN_W-1:0] SMP_WIDE   = RN_W'(SMP_N + EXTRA_N);
    localparam logic [RN_W-1:0] FSO_NARROW = RN_W'(SMP_N + 1);
    localparam logic [RN_W-1:0] FSO_WIDE   = RN_W'(SMP_N + EXTRA_N + 1);
    localparam logic [CNT_W-1:0] CNT_MAX   = '1;

    logic [1:0]       e_rise, e_fall;
    edge_t            cs_ev, sc_ev;
    logic             fs_q, fs_fall;
    logic             dsp_on, busy, wide_q;
    logic [CNT_W-1:0] cnt;
    logic [RN_W-1:0]  rnum, smp_at, fso_at;
    logic             frame_start, step_ok;
    logic             cmd_fall, tx_clear, tx_load, tx_shift;

    dsp_edge_det #(
        .N       (2),
        .RST_VAL (2'b01)
    ) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   ({sclk, cs_n}),
        .rise  (e_rise),
        .fall  (e_fall)
    );

    assign cs_ev = '{rise: e_rise[0], fall: e_fall[0]};
    assign sc_ev = '{rise: e_rise[1], fall: e_fall[1]};

    // Previous frame-sync level, for its falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) fs_q <= 1'b0;
        else        fs_q <= fs_in;
    end

    assign fs_fall     = fs_q & ~fs_in;
    assign frame_start = fs_fall & dsp_on & ~cs_n;
    assign step_ok     = busy & ~cs_ev.rise & ~cs_ev.fall & ~frame_start;
    assign rnum        = {1'b0, cnt} + RN_W'(1);
    assign smp_at      = wide_q ? SMP_WIDE : SMP_NARROW;
    assign fso_at      = wide_q ? FSO_WIDE : FSO_NARROW;

    // Mode, shutdown, cycle count and rising-edge strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shutdown   <= 1'b1;
            dsp_on     <= 1'b0;
            busy       <= 1'b0;
            wide_q     <= 1'b0;
            cnt        <= '0;
            fs_out     <= 1'b0;
            sample_stb <= 1'b0;
        end else begin
            fs_out     <= 1'b0;
            sample_stb <= 1'b0;
            if (cs_ev.rise) begin
                shutdown <= 1'b1;
                dsp_on   <= 1'b0;
                busy     <= 1'b0;
            end else if (cs_ev.fall) begin
                shutdown <= 1'b0;
                dsp_on   <= ~fs_in;
                busy     <= 1'b0;
            end else if (frame_start) begin
                busy   <= 1'b1;
                cnt    <= '0;
                wide_q <= wide_sel;
            end else if (busy) begin
                if (sc_ev.fall && cnt != CNT_MAX)
                    cnt <= cnt + CNT_W'(1);
                if (sc_ev.rise) begin
                    sample_stb <= (rnum == smp_at);
                    fs_out     <= (rnum == fso_at);
                end
            end
        end
    end

    assign cmd_fall = step_ok & sc_ev.fall;
    assign tx_clear = cs_ev.rise | cs_ev.fall | frame_start;
    assign tx_load  = step_ok & sc_ev.rise & (rnum == fso_at);
    assign tx_shift = step_ok & sc_ev.rise & (rnum > fso_at);

    dsp_cmd_shift #(
        .CMD_W  (CMD_W),
        .CHAN_W (CHAN_W),
        .CNT_W  (CNT_W),
        .ACQ_N  (ACQ_N)
    ) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (frame_start),
        .fall_evt  (cmd_fall),
        .cnt       (cnt),
        .din       (din),
        .cmd_q     (cmd_q),
        .chan_sel  (chan_sel),
        .acq_start (acq_start)
    );

    dsp_tx_shift #(
        .RES_W  (RES_W),
        .SLOT_W (SLOT_W)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (tx_clear),
        .load      (tx_load),
        .shift     (tx_shift),
        .result_in (result_in),
        .dout      (dout)
    );
endmodule

// File: rtl/dsp_fs_adc_if_chk.sv
// Checker for the converter port, bound to every instance of the top.
// Assumes serial-clock phases of at least two clk cycles.
module dsp_fs_adc_if_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic dout,
    input logic fs_out,
    input logic acq_start,
    input logic sample_stb,
    input logic shutdown
);
    AST_SHUT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> (!dout && !fs_out && !sample_stb && !acq_start)); // R10

    AST_CS_RISE_SHUTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> shutdown); // R10

    AST_FSO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fs_out |=> !fs_out); // R6

    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb); // R5

    AST_STB_NOT_FSO: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && fs_out)); // R6

    AST_NO_DATA_AT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> !dout); // R7
endmodule

bind dsp_fs_adc_if dsp_fs_adc_if_chk u_chk (.*);

// File: tb/tb_dsp_fs_adc_if.sv
// Bench for the converter port: a vector table of frames, then directed
// tests for reset, mode entry, retrigger abort, width latching and shutdown.
module tb_dsp_fs_adc_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        fs_in = 1'b0;
    logic        din = 1'b0;
    logic        wide_sel = 1'b0;
    logic [13:0] result_in = '0;
    logic        dout, fs_out, acq_start, sample_stb, shutdown;
    logic [1:0]  chan_sel;
    logic [7:0]  cmd_q;

    int n_run = 0;
    int n_fail = 0;

    // Per-frame observations
    int   stb_at, stb_cnt, fso_at, fso_cnt, acq_at, acq_cnt;
    logic dbits [64];

    always #5 clk = ~clk;

    dsp_fs_adc_if dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .fs_in(fs_in),
        .din(din), .wide_sel(wide_sel), .result_in(result_in), .dout(dout),
        .fs_out(fs_out), .acq_start(acq_start), .sample_stb(sample_stb),
        .chan_sel(chan_sel), .cmd_q(cmd_q), .shutdown(shutdown)
    );

    // Frames as {wide, command, result}
    localparam logic [22:0] VEC [4] = '{
        {1'b0, 8'h00, 14'h0001},
        {1'b1, 8'h9A, 14'h2A5B},
        {1'b0, 8'h7F, 14'h3FFF},
        {1'b1, 8'hC3, 14'h1234}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Frame-sync pulse, width taken at the falling edge, then ncyc serial cycles
    task automatic run_frame(input logic w, input logic w_mid,
                             input logic [7:0] c, input int ncyc);
        stb_at = 0; stb_cnt = 0; fso_at = 0; fso_cnt = 0; acq_at = 0; acq_cnt = 0;
        for (int i = 0; i < 64; i++) dbits[i] = 1'b0;
        wide_sel = w;
        @(negedge clk) fs_in = 1'b1;
        idle(2);
        fs_in = 1'b0;
        idle(2);
        wide_sel = w_mid;
        for (int k = 1; k <= ncyc; k++) begin
            sclk = 1'b1;
            din  = (k <= 8) ? c[8-k] : 1'b0;
            @(negedge clk);
            if (sample_stb) begin stb_at = k; stb_cnt++; end
            if (fs_out)     begin fso_at = k; fso_cnt++; end
            if (acq_start)  begin acq_at = k; acq_cnt++; end
            dbits[k] = dout;
            idle(2);
            sclk = 1'b0;
            @(negedge clk);
            if (acq_start)  begin acq_at = k; acq_cnt++; end
            if (sample_stb) stb_cnt++;
            if (fs_out)     fso_cnt++;
            idle(2);
        end
    endtask

    // Compare a whole frame against the requirements
    task automatic check_frame(input logic w, input logic [7:0] c,
                               input logic [13:0] res, input int ncyc);
        int f = w ? 16 : 8;
        logic [15:0] slot = {res, 2'b00};
        logic [15:0] got;
        int stray = 0;
        chk("R5 sample rise", stb_at, w ? 15 : 7);
        chk("R5 sample count", stb_cnt, 1);
        chk("R6 fs_out rise", fso_at, f);
        chk("R6 fs_out count", fso_cnt, 1);
        chk("R4 acq fall", acq_at, 3);
        chk("R3 command", int'(cmd_q), int'(c));
        chk("R3 channel", int'(chan_sel), int'(c[7:6]));
        for (int j = 1; j <= 16; j++) got[16-j] = dbits[f+j];
        chk("R7 data", int'(got), int'(slot));
        for (int k = 1; k <= ncyc; k++)
            if ((k <= f || k > f + 16) && dbits[k] !== 1'b0) stray++;
        chk("R8 zero fill", stray, 0);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle(4);
        // R1 reset values
        chk("R1 shutdown", int'(shutdown), 1);
        chk("R1 dout", int'(dout), 0);
        chk("R1 pulses", int'(fs_out | sample_stb | acq_start), 0);
        chk("R1 cmd/chan", int'({chan_sel, cmd_q}), 0);
        rst_n = 1'b1;
        idle(3);
        chk("R1 shutdown after release", int'(shutdown), 1);

        // R2 chip select falls with frame sync high: not enabled
        fs_in = 1'b1; idle(2);
        cs_n = 1'b0; idle(2);
        fs_in = 1'b0; idle(2);
        chk("R10 shutdown cleared", int'(shutdown), 0);
        run_frame(1'b0, 1'b0, 8'hAA, 24);
        chk("R2 disabled no strobe", stb_cnt + fso_cnt, 0);

        // R2 proper entry
        cs_n = 1'b1; idle(3);
        cs_n = 1'b0; idle(3);

        for (int v = 0; v < 4; v++) begin
            result_in = VEC[v][13:0];
            run_frame(VEC[v][22], VEC[v][22], VEC[v][21:14], VEC[v][22] ? 36 : 28);
            check_frame(VEC[v][22], VEC[v][21:14], VEC[v][13:0], VEC[v][22] ? 36 : 28);
        end

        // R9 retrigger after the result started, then a full frame
        result_in = 14'h0F0F;
        run_frame(1'b0, 1'b0, 8'h40, 11);
        result_in = 14'h3A5C;
        run_frame(1'b0, 1'b0, 8'h80, 28);
        check_frame(1'b0, 8'h80, 14'h3A5C, 28);   // R9

        // R9 retrigger before sampling
        run_frame(1'b1, 1'b1, 8'hFF, 5);
        chk("R9 early abort no sample", stb_cnt, 0);
        result_in = 14'h1111;
        run_frame(1'b0, 1'b0, 8'h55, 28);
        check_frame(1'b0, 8'h55, 14'h1111, 28);   // R9

        // R11 width held from frame start
        result_in = 14'h2222;
        run_frame(1'b1, 1'b0, 8'hC0, 36);
        check_frame(1'b1, 8'hC0, 14'h2222, 36);   // R11

        // R10 chip select rises mid-frame
        result_in = 14'h3FFF;
        run_frame(1'b0, 1'b0, 8'h00, 12);
        cs_n = 1'b1; idle(2);
        chk("R10 shutdown set", int'(shutdown), 1);
        chk("R10 dout forced low", int'(dout), 0);
        run_frame(1'b0, 1'b0, 8'hFF, 24);
        chk("R10 no pulses in shutdown", stb_cnt + fso_cnt + acq_cnt, 0);
        chk("R10 dout stays low", int'(dbits[9] | dbits[10] | dbits[12]), 0);

        // R10 re-entry
        fs_in = 1'b0; idle(2);
        cs_n = 1'b0; idle(2);
        chk("R10 shutdown cleared again", int'(shutdown), 0);
        result_in = 14'h0ABC;
        run_frame(1'b0, 1'b0, 8'h3C, 28);
        check_frame(1'b0, 8'h3C, 14'h0ABC, 28);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule